// File: doc/BRIEF.md
# Block-transfer DMA engine

A single-channel engine that copies a block of memory from a source region to a destination region without processor involvement. Software programs a source address, a destination address and a count of transfer units through a small register file, selects how each address moves after a unit and how large a unit is, and then raises a global enable and a channel enable. The engine then issues read beats followed by write beats on a simple request/ready memory master port until the count is exhausted.

Each unit is gathered into an internal buffer by consecutive reads and then emptied by consecutive writes. Addresses are cut to a 29-bit physical range on the bus. A unit whose source or destination is not aligned to the unit size, or an unsupported size code, raises a sticky error flag and stops the channel before any access for that unit. Completion and error are both flags that software polls and clears.

Top module: `blk_xfer_dma`

## Requirements
- R1: After reset every register reads zero (select 0 source, 1 destination, 2 count, 3 control, 4 operation) and no memory request is raised.
- R2: Transfers start only when the operation register bit 0 (global enable) and control bit 0 (channel enable) are both set and control bits [11:8] hold request code 0100 (automatic); any other combination issues no memory access.
- R3: With size code 0100 in control bits [15:12] a unit is 32 bytes: eight 32-bit reads from the source followed by eight writes to the destination carrying the read data in order; the count register drops by one per completed unit.
- R4: Address mode is in control bits [7:6] for source and [5:4] for destination: 00 keeps the address fixed for every beat and unit, 01 steps beats upward and adds the unit size after each unit, 10 steps beats upward and subtracts the unit size after each unit; the registers read back the updated addresses.
- R5: Every address on the memory bus equals the register address ANDed with 0x1FFFFFFF.
- R6: When the count is zero the channel sets the end flag (control bit 1) and makes no further access, including when it is started with a count of zero.
- R7: A source or destination address not aligned to the unit size sets the error flag (operation bit 2), leaves the count unchanged and makes no access for that unit.
- R8: A size code other than 0010, 0011 or 0100 sets the error flag without any access.
- R9: The end flag stays set when control is written with bit 1 at one and clears when it is written with bit 1 at zero; no transfer starts while it is set.
- R10: The error flag clears only when the operation register is written with bit 2 at zero; no transfer starts while it is set.
- R11: Clearing the channel enable while a unit is in progress lets that unit finish and starts no further unit.
- R12: Size code 0010 moves 4-byte units (one read, one write) and size code 0011 moves 16-byte units (four reads, four writes).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write when high |
| mem_addr | output | 32 | Physical beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read beat data, valid with mem_ready |

## Verification
The hardest case is removing the channel enable while a unit is already moving, since the write must land after the engine has committed to the unit but well before its last write beat. The bench issues the disabling write one cycle after the enabling one while the memory side stalls one cycle in three, so the first unit is still in its read phase; the scoreboard then holds exactly one unit of expected beats and the count must read one less than programmed. Errors are reached by programming a misaligned source or an unknown size code, and the flags are then cleared with and without the relevant bit to show their stickiness.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  // address stepping modes
  localparam logic [1:0] AM_FIXED = 2'b00;
  localparam logic [1:0] AM_INC   = 2'b01;
  localparam logic [1:0] AM_DEC   = 2'b10;

  localparam logic [3:0]  REQ_AUTO  = 4'b0100;
  localparam logic [31:0] PHYS_MASK = 32'h1FFF_FFFF;

  localparam logic [2:0] SEL_SRC = 3'd0;
  localparam logic [2:0] SEL_DST = 3'd1;
  localparam logic [2:0] SEL_CNT = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_OPR = 3'd4;

  typedef struct packed {
    logic [3:0] usize;
    logic [3:0] req;
    logic [1:0] smode;
    logic [1:0] dmode;
  } chan_cfg_t;

  // beats of 32 bits per unit; zero marks an unsupported code
  function automatic logic [3:0] unit_beats(input logic [3:0] code);
    case (code)
      4'b0010: return 4'd1;
      4'b0011: return 4'd4;
      4'b0100: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          unit_done,
  input  logic          te_set,
  input  logic          ae_set,
  input  logic [AW-1:0] nxt_src,
  input  logic [AW-1:0] nxt_dst,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output chan_cfg_t     cfg_q,
  output logic          ch_en_q,
  output logic          te_q,
  output logic          men_q,
  output logic          ae_q
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_d;
  chan_cfg_t     cfg_d;
  logic          ch_en_d, te_d, men_d, ae_d;
  logic          wr_src, wr_dst, wr_cnt, wr_ctl, wr_opr;
  logic          addr_en, ctl_en, opr_en;

  assign wr_src = cfg_we && (cfg_sel == SEL_SRC);
  assign wr_dst = cfg_we && (cfg_sel == SEL_DST);
  assign wr_cnt = cfg_we && (cfg_sel == SEL_CNT);
  assign wr_ctl = cfg_we && (cfg_sel == SEL_CTL);
  assign wr_opr = cfg_we && (cfg_sel == SEL_OPR);

  assign addr_en = unit_done | wr_src | wr_dst | wr_cnt;
  assign ctl_en  = wr_ctl | te_set;
  assign opr_en  = wr_opr | ae_set;

  always_comb begin
    src_d   = unit_done ? nxt_src : src_q;
    dst_d   = unit_done ? nxt_dst : dst_q;
    cnt_d   = unit_done ? (cnt_q - CNT_ONE) : cnt_q;
    cfg_d   = cfg_q;
    ch_en_d = ch_en_q;
    te_d    = te_q;
    men_d   = men_q;
    ae_d    = ae_q;
    if (wr_src) src_d = cfg_wdata[AW-1:0];
    if (wr_dst) dst_d = cfg_wdata[AW-1:0];
    if (wr_cnt) cnt_d = cfg_wdata[CW-1:0];
    if (wr_ctl) begin
      cfg_d   = cfg_wdata[15:4];
      ch_en_d = cfg_wdata[0];
      te_d    = te_q & cfg_wdata[1];   // software may only clear
    end
    if (wr_opr) begin
      men_d = cfg_wdata[0];
      ae_d  = ae_q & cfg_wdata[2];     // software may only clear
    end
    if (te_set) te_d = 1'b1;
    if (ae_set) ae_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (addr_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ch_en_q <= 1'b0;
      te_q    <= 1'b0;
    end else if (ctl_en) begin
      cfg_q   <= cfg_d;
      ch_en_q <= ch_en_d;
      te_q    <= te_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= 1'b0;
      ae_q  <= 1'b0;
    end else if (opr_en) begin
      men_q <= men_d;
      ae_q  <= ae_d;
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_SRC: cfg_rdata = 32'(src_q);
      SEL_DST: cfg_rdata = 32'(dst_q);
      SEL_CNT: cfg_rdata = 32'(cnt_q);
      SEL_CTL: cfg_rdata = {16'h0, cfg_q, 2'b00, te_q, ch_en_q};
      SEL_OPR: cfg_rdata = {29'h0, ae_q, 1'b0, men_q};
      default: cfg_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_cfg_t     cfg,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          ch_en,
  input  logic          te,
  input  logic          men,
  input  logic          ae,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] beat,
  output logic          cap_en,
  output logic          unit_done,
  output logic          te_set,
  output logic          ae_set,
  output logic [AW-1:0] nxt_src,
  output logic [AW-1:0] nxt_dst
);
  localparam int            LANE_SH = $clog2(DW / 8);
  localparam logic [BW-1:0] B_ONE   = BW'(1);

  xfer_st_e      st_q, st_d;
  logic [BW-1:0] beat_d;
  logic [BW:0]   beats;
  logic [AW-1:0] unit_bytes, align_mask, beat_off, src_a, dst_a;
  logic          armed, misal, go, last, seq_en;

  assign beats      = (BW+1)'(unit_beats(cfg.usize));
  assign unit_bytes = AW'(beats) << LANE_SH;
  assign align_mask = unit_bytes - AW'(1);
  assign misal      = |((src | dst) & align_mask);
  assign last       = ({1'b0, beat} == (beats - (BW+1)'(1)));

  assign armed  = (st_q == ST_IDLE) && men && ch_en && !te && !ae && (cfg.req == REQ_AUTO);
  assign te_set = armed && (cnt == '0);
  assign ae_set = armed && (cnt != '0) && ((beats == '0) || misal);
  assign go     = armed && (cnt != '0) && (beats != '0) && !misal;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input logic [1:0] mode,
                                              input logic [AW-1:0] off);
    return (mode == AM_INC || mode == AM_DEC) ? base + off : base;
  endfunction

  function automatic logic [AW-1:0] unit_step(input logic [AW-1:0] base,
                                              input logic [1:0] mode,
                                              input logic [AW-1:0] amt);
    case (mode)
      AM_INC:  return base + amt;
      AM_DEC:  return base - amt;
      default: return base;
    endcase
  endfunction

  assign beat_off = AW'(beat) << LANE_SH;
  assign src_a    = beat_addr(src, cfg.smode, beat_off);
  assign dst_a    = beat_addr(dst, cfg.dmode, beat_off);
  assign nxt_src  = unit_step(src, cfg.smode, unit_bytes);
  assign nxt_dst  = unit_step(dst, cfg.dmode, unit_bytes);

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (mem_we ? dst_a : src_a) & AW'(PHYS_MASK);
  assign cap_en    = (st_q == ST_RD) && mem_ready;
  assign unit_done = (st_q == ST_WR) && mem_ready && last;
  assign seq_en    = go || (mem_req && mem_ready);

  always_comb begin
    st_d   = st_q;
    beat_d = beat;
    case (st_q)
      ST_IDLE: if (go) begin
        st_d   = ST_RD;
        beat_d = '0;
      end
      ST_RD: if (mem_ready) begin
        st_d   = last ? ST_WR : ST_RD;
        beat_d = last ? '0 : beat + B_ONE;
      end
      ST_WR: if (mem_ready) begin
        st_d   = last ? ST_IDLE : ST_WR;
        beat_d = last ? '0 : beat + B_ONE;
      end
      default: begin
        st_d   = ST_IDLE;
        beat_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      beat <= '0;
    end else if (seq_en) begin
      st_q <= st_d;
      beat <= beat_d;
    end
  end

endmodule

// File: rtl/blkdma_ubuf.sv
module blkdma_ubuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DEPTH-1:0][DW-1:0] ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          hit;
    logic [DW-1:0] q;
    assign hit = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (hit) q <= wr_data;
    end
    assign ent[i] = q;
  end

  assign rd_data = ent[rd_idx];

endmodule

// File: rtl/blk_xfer_dma.sv
module blk_xfer_dma
  import blkdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 24,
  parameter int DW        = 32,
  parameter int MAX_BEATS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = $clog2(MAX_BEATS);

  logic [1:0]    rsync;
  logic          rst_sn;
  logic [AW-1:0] src_q, dst_q, nxt_src, nxt_dst;
  logic [CW-1:0] cnt_q;
  chan_cfg_t     cfg_q;
  logic          ch_en_q, te_q, men_q, ae_q;
  logic          unit_done, te_set, ae_set, cap_en;
  logic [BW-1:0] beat;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_sn = rsync[1];

  blkdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .unit_done(unit_done), .te_set(te_set), .ae_set(ae_set),
    .nxt_src(nxt_src), .nxt_dst(nxt_dst),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cfg_q(cfg_q),
    .ch_en_q(ch_en_q), .te_q(te_q), .men_q(men_q), .ae_q(ae_q)
  );

  blkdma_seq #(.AW(AW), .CW(CW), .DW(DW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .cfg(cfg_q), .src(src_q), .dst(dst_q), .cnt(cnt_q),
    .ch_en(ch_en_q), .te(te_q), .men(men_q), .ae(ae_q),
    .mem_ready(mem_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .beat(beat), .cap_en(cap_en), .unit_done(unit_done),
    .te_set(te_set), .ae_set(ae_set), .nxt_src(nxt_src), .nxt_dst(nxt_dst)
  );

  blkdma_ubuf #(.DW(DW), .DEPTH(MAX_BEATS), .IW(BW)) u_buf (
    .clk(clk), .wr_en(cap_en), .wr_idx(beat), .wr_data(mem_rdata),
    .rd_idx(beat), .rd_data(mem_wdata)
  );

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          te,
  input logic          ae,
  input logic          men,
  input logic          ch_en,
  input logic [CW-1:0] cnt
);

  // R5
  phys_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((32'(mem_addr) & 32'hE000_0000) == 32'h0));

  // R3
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae |-> !mem_req);

  // R9
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !(cfg_we && cfg_sel == 3'd3)) |=> te);

  // R9
  end_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !mem_req) |=> !mem_req);

  // R6
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cnt != '0));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(men && ch_en));

endmodule

bind blk_xfer_dma blkdma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .te(te_q), .ae(ae_q), .men(men_q), .ch_en(ch_en_q), .cnt(cnt_q)
);

// File: tb/sim_blk_xfer_dma.sv
module sim_blk_xfer_dma;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } beat_t;

  logic        clk, rst_n, cfg_we, mem_ready;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we;

  beat_t exp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    closed = 0;
  int    rdy_cnt = 0;

  blk_xfer_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ a[15:0]};
  endfunction

  assign mem_rdata = rd_pat(mem_addr);

  // control word: [0] enable [1] end flag [5:4] dst mode [7:6] src mode [11:8] req [15:12] size
  function automatic logic [31:0] ctl_w(input bit en, input bit te, input logic [1:0] dm,
                                        input logic [1:0] sm, input logic [3:0] rq,
                                        input logic [3:0] sz);
    return {16'h0, sz, rq, sm, dm, 2'b00, te, en};
  endfunction

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    mem_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      rdy_cnt++;
      mem_ready = (rdy_cnt % 3) != 2;
    end
  end

  task automatic summary();
    if (!closed) begin
      closed = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // monitor: compare every accepted beat with the scoreboard
  initial begin
    beat_t e;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && mem_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected access we=%0d addr=%h, expected none", mem_we, mem_addr);
        end else begin
          e = exp_q.pop_front();
          if (mem_we !== e.we || mem_addr !== e.addr || (mem_we && mem_wdata !== e.data)) begin
            n_fail++;
            $display("FAIL %s beat we=%0d addr=%h data=%h, expected we=%0d addr=%h data=%h",
                     e.tag, mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    cfg_sel = s;
    #1 v = cfg_rdata;
  endtask

  // driver: push the beats a job is required to produce
  task automatic push_job(input logic [31:0] s0, input logic [31:0] d0,
                          input logic [1:0] sm, input logic [1:0] dm,
                          input int beats, input int units, input string tag);
    logic [31:0] s, d, ra, wa;
    s = s0; d = d0;
    for (int u = 0; u < units; u++) begin
      for (int k = 0; k < beats; k++) begin
        ra = ((sm == 2'b01 || sm == 2'b10) ? s + 32'(4*k) : s) & 32'h1FFF_FFFF;
        exp_q.push_back('{1'b0, ra, rd_pat(ra), tag});
      end
      for (int k = 0; k < beats; k++) begin
        ra = ((sm == 2'b01 || sm == 2'b10) ? s + 32'(4*k) : s) & 32'h1FFF_FFFF;
        wa = ((dm == 2'b01 || dm == 2'b10) ? d + 32'(4*k) : d) & 32'h1FFF_FFFF;
        exp_q.push_back('{1'b1, wa, rd_pat(ra), tag});
      end
      s = (sm == 2'b01) ? s + 32'(4*beats) : (sm == 2'b10) ? s - 32'(4*beats) : s;
      d = (dm == 2'b01) ? d + 32'(4*beats) : (dm == 2'b10) ? d - 32'(4*beats) : d;
    end
  endtask

  task automatic wait_end(input string tag);
    logic [31:0] c, o;
    bit seen;
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(3'd3, c);
      rd(3'd4, o);
      seen = c[1] | o[2];
    end
    chk({tag, " job ended"}, 32'(seen), 32'd1);
    chk({tag, " all expected beats seen"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 no request after reset", 32'(mem_req), 32'd0);

    // R2: enables and request code gate the start
    wr(3'd0, 32'hA81A_0000);
    wr(3'd1, 32'hB400_0C00);
    wr(3'd2, 32'd2);
    wr(3'd3, ctl_w(1, 0, 2'b00, 2'b01, 4'b0100, 4'b0100));
    repeat (40) @(negedge clk);
    rd(3'd2, v); chk("R2 master off keeps count", v, 32'd2);
    wr(3'd3, ctl_w(1, 0, 2'b00, 2'b01, 4'b0000, 4'b0100));
    wr(3'd4, 32'h1);
    repeat (40) @(negedge clk);
    rd(3'd2, v); chk("R2 non-auto request keeps count", v, 32'd2);

    // R3 R4 R5: 32-byte units, source increments, destination fixed, masked bus addresses
    push_job(32'hA81A_0000, 32'hB400_0C00, 2'b01, 2'b00, 8, 2, "R3");
    wr(3'd3, ctl_w(1, 0, 2'b00, 2'b01, 4'b0100, 4'b0100));
    wait_end("R3");
    rd(3'd2, v); chk("R3 count reaches zero", v, 32'd0);
    rd(3'd0, v); chk("R4 source advanced by two units", v, 32'hA81A_0040);
    rd(3'd1, v); chk("R4 fixed destination unchanged", v, 32'hB400_0C00);
    rd(3'd3, v); chk("R6 end flag set", v & 32'h2, 32'h2);

    // R9: end flag sticky and blocking
    wr(3'd3, ctl_w(1, 1, 2'b00, 2'b01, 4'b0100, 4'b0100));
    wr(3'd2, 32'd1);
    repeat (30) @(negedge clk);
    rd(3'd3, v); chk("R9 end flag kept by write of one", v & 32'h2, 32'h2);
    rd(3'd2, v); chk("R9 no start while end flag set", v, 32'd1);
    push_job(32'hA81A_0040, 32'hB400_0C00, 2'b01, 2'b00, 8, 1, "R9");
    wr(3'd3, ctl_w(1, 0, 2'b00, 2'b01, 4'b0100, 4'b0100));
    wait_end("R9");
    rd(3'd0, v); chk("R9 restarted job advanced source", v, 32'hA81A_0060);

    // R12 R4: 16-byte units, source decrements, destination increments
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'h0000_0200);
    wr(3'd2, 32'd2);
    push_job(32'h100, 32'h200, 2'b10, 2'b01, 4, 2, "R12");
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b10, 4'b0100, 4'b0011));
    wait_end("R12");
    rd(3'd0, v); chk("R4 decrementing source", v, 32'h0000_00E0);
    rd(3'd1, v); chk("R4 incrementing destination", v, 32'h0000_0220);

    // R12: 4-byte units
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'd3);
    push_job(32'h1000, 32'h2000, 2'b01, 2'b01, 1, 3, "R12");
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b01, 4'b0100, 4'b0010));
    wait_end("R12");
    rd(3'd0, v); chk("R12 single-beat source step", v, 32'h0000_100C);

    // R6: start with count zero
    wr(3'd2, 32'd0);
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b01, 4'b0100, 4'b0100));
    wait_end("R6");
    rd(3'd3, v); chk("R6 end flag with zero count", v & 32'h2, 32'h2);
    rd(3'd4, v); chk("R6 no error with zero count", v, 32'h1);

    // R7: misaligned source
    wr(3'd0, 32'h0000_0104);
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'd1);
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b01, 4'b0100, 4'b0100));
    wait_end("R7");
    rd(3'd4, v); chk("R7 error flag set", v, 32'h5);
    rd(3'd2, v); chk("R7 count untouched", v, 32'd1);
    rd(3'd3, v); chk("R7 end flag clear", v & 32'h2, 32'h0);

    // R10: error flag sticky, blocks, cleared by write of zero
    wr(3'd4, 32'h5);
    wr(3'd0, 32'h0000_0100);
    repeat (30) @(negedge clk);
    rd(3'd4, v); chk("R10 error kept by write of one", v, 32'h5);
    rd(3'd2, v); chk("R10 no start while error set", v, 32'd1);
    push_job(32'h100, 32'h2000, 2'b01, 2'b01, 8, 1, "R10");
    wr(3'd4, 32'h1);
    wait_end("R10");
    rd(3'd4, v); chk("R10 error cleared", v, 32'h1);

    // R8: unsupported size code
    wr(3'd2, 32'd1);
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b01, 4'b0100, 4'b0111));
    wait_end("R8");
    rd(3'd4, v); chk("R8 error on bad size", v, 32'h5);
    rd(3'd2, v); chk("R8 count untouched", v, 32'd1);
    wr(3'd3, ctl_w(0, 0, 2'b01, 2'b01, 4'b0100, 4'b0100));
    wr(3'd4, 32'h1);

    // R11: enable removed during the first unit
    wr(3'd0, 32'h0000_3000);
    wr(3'd1, 32'h0000_4000);
    wr(3'd2, 32'd3);
    push_job(32'h3000, 32'h4000, 2'b01, 2'b01, 8, 1, "R11");
    wr(3'd3, ctl_w(1, 0, 2'b01, 2'b01, 4'b0100, 4'b0100));
    wr(3'd3, ctl_w(0, 0, 2'b01, 2'b01, 4'b0100, 4'b0100));
    repeat (300) @(negedge clk);
    chk("R11 current unit completed", 32'(exp_q.size()), 32'd0);
    rd(3'd2, v); chk("R11 only one unit moved", v, 32'd2);
    rd(3'd0, v); chk("R11 source after one unit", v, 32'h0000_3020);
    rd(3'd3, v); chk("R11 no end flag", v & 32'h2, 32'h0);

    summary();
  end

endmodule